// File: doc/BRIEF.md
# Backplane slave access sequencer

This block is the target-side sequencer for a synchronous backplane that multiplexes address and data on one set of lines. When a start cycle on the bus is addressed to this board, it tells local logic that a remote master wants access. It then opens the board's address/data buffers while local logic grants the access. It drives the bus acknowledge once local logic reports completion. An external comparator, not part of this block, matches the bus address against the board's 4-bit ID and gives the result on `id_match`.

The bus has two clock edges: one edge drives signals and the other samples them. Here both come from a single system clock as a drive strobe and a sample strobe, half a bus period apart. All bus and local inputs are taken only at the sample strobe. The bus acknowledge changes only at the drive strobe. Local logic can shorten an access by granting early, or by granting and acknowledging early, which gives an acknowledge on the very next drive strobe. A lock flag tells local logic to leave its resources alone. It is set by an attention-lock cycle that arrives during an access and cleared by an attention-null cycle.

Top module: `bus_slave_hs`

## Requirements
- R1: One bus period is 2*HALF_CYC system clocks. The drive strobe falls on the first clock edge after reset is released and every period after that. The sample strobe falls HALF_CYC edges after each drive strobe. No output changes on an edge that carries neither strobe, and `ack_out` changes only on drive strobes.
- R2: While reset is held, and after the first edge that follows reset, `req_stat`, `buf_en`, `ack_out` and `lock_out` are all 0.
- R3: An access begins at a sample strobe where `bus_start`=1, `bus_ack`=0 and `id_match`=1. From that edge `req_stat` is 1. A start without `id_match`, or an attention cycle (`bus_start`=1 with `bus_ack`=1), does not begin an access.
- R4: During an access, each sample strobe loads `buf_en` with the inverse of `grant_n`. This includes the sample strobe that begins the access, so a grant that is already low opens the buffers at once.
- R5: Once local acknowledge has been taken, the access ends at the next sample strobe at which `grant_n` is 1. At that edge `req_stat` and `buf_en` both go to 0, and not before.
- R6: `lack_n`=0 seen at a sample strobe during an access makes `ack_out` 1 from the following drive strobe (HALF_CYC edges later) for exactly one bus period. There is one such pulse per access.
- R7: If `grant_n`=0 and `lack_n`=0 at the sample strobe that begins the access, `ack_out` rises at the next drive strobe.
- R8: There is no timeout. An access stays active, with `req_stat`=1, until local acknowledge is taken. A bus acknowledge or a new start cycle seen during the access has no effect.
- R9: An attention cycle with `bus_tm`=1 (lock), sampled while `req_stat` is 1, sets `lock_out` to 1 at that sample strobe.
- R10: `lock_out` stays 1 after the access ends. It is cleared at a sample strobe that sees an attention cycle with `bus_tm`=0 (null). An attention-lock cycle while no access is active leaves `lock_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both bus strobes are derived from it |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Bus start indication, active high |
| bus_ack | input | 1 | Bus acknowledge from other agents, active high |
| bus_tm | input | 1 | Transfer-mode bit; in an attention cycle 1 = lock, 0 = null |
| id_match | input | 1 | External comparator result: bus address equals board ID |
| grant_n | input | 1 | Local grant, active low |
| lack_n | input | 1 | Local acknowledge, active low |
| req_stat | output | 1 | Remote access in progress, to local logic |
| buf_en | output | 1 | Address/data buffer enable onto the local board |
| ack_out | output | 1 | Acknowledge driven onto the bus |
| lock_out | output | 1 | Lock condition: local resources must not be modified |

## Verification
The bound checker watches every cycle for the strobe discipline. It flags any output that moves between strobes, an acknowledge that rises off a drive strobe or lasts less than a full strobe spacing, a request that rises without a matching start, a request that ends while grant is still low, buffers open without a request, and a lock that sets outside an access. What the actual values are at each strobe, and how many bus periods each path takes, can only be shown by the bench scenarios. These cover the plain handshake, early grant, early grant with acknowledge, a long-delayed local acknowledge with bus timeout traffic, and the setting, holding and clearing of the lock flag.

// File: rtl/bus_slave_hs_pkg.sv
package bus_slave_hs_pkg;
  typedef enum logic {
    ACC_IDLE = 1'b0,
    ACC_BUSY = 1'b1
  } acc_state_t;
endpackage

// File: rtl/bus_slave_hs_phase.sv
// Derives the bus drive and sample strobes from the system clock.
module bus_slave_hs_phase #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  output logic drv_stb,
  output logic smp_stb
);
  localparam int PERIOD = 2 * HALF_CYC;
  localparam int PW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= '0;
    end else if (ph_q == PW'(PERIOD - 1)) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign drv_stb = ~rst && (ph_q == '0);
  assign smp_stb = ~rst && (ph_q == PW'(HALF_CYC));
endmodule

// File: rtl/bus_slave_hs_access.sv
// Slave access sequencer: request status, buffer enable and bus acknowledge.
module bus_slave_hs_access
  import bus_slave_hs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic drv_stb,
  input  logic smp_stb,
  input  logic start_hit,
  input  logic grant_n,
  input  logic lack_n,
  output logic req_stat,
  output logic buf_en,
  output logic ack_out
);
  acc_state_t state_q;
  logic       taken_q;   // local acknowledge already accepted
  logic       pend_q;    // acknowledge waiting for the drive strobe

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ACC_IDLE;
      taken_q  <= 1'b0;
      pend_q   <= 1'b0;
      req_stat <= 1'b0;
      buf_en   <= 1'b0;
      ack_out  <= 1'b0;
    end else begin
      if (drv_stb) begin
        ack_out <= pend_q;
        pend_q  <= 1'b0;
      end
      if (smp_stb) begin
        unique case (state_q)
          ACC_IDLE: begin
            if (start_hit) begin
              state_q  <= ACC_BUSY;
              req_stat <= 1'b1;
              buf_en   <= ~grant_n;
              // fastest path: grant and acknowledge already present
              taken_q  <= ~grant_n & ~lack_n;
              pend_q   <= ~grant_n & ~lack_n;
            end
          end
          ACC_BUSY: begin
            if (taken_q && grant_n) begin
              state_q  <= ACC_IDLE;
              req_stat <= 1'b0;
              buf_en   <= 1'b0;
              taken_q  <= 1'b0;
            end else begin
              buf_en <= ~grant_n;
              if (!taken_q && !lack_n) begin
                taken_q <= 1'b1;
                pend_q  <= 1'b1;
              end
            end
          end
          default: state_q <= ACC_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bus_slave_hs_lock.sv
// Tracks the lock window opened by attention-lock and closed by attention-null.
module bus_slave_hs_lock (
  input  logic clk,
  input  logic rst,
  input  logic smp_stb,
  input  logic attn,
  input  logic lock_sel,
  input  logic busy,
  output logic lock_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_out <= 1'b0;
    end else if (smp_stb && attn) begin
      if (!lock_sel) begin
        lock_out <= 1'b0;
      end else if (busy) begin
        lock_out <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_slave_hs.sv
module bus_slave_hs #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_start,
  input  logic bus_ack,
  input  logic bus_tm,
  input  logic id_match,
  input  logic grant_n,
  input  logic lack_n,
  output logic req_stat,
  output logic buf_en,
  output logic ack_out,
  output logic lock_out
);
  logic drv_stb;
  logic smp_stb;
  logic start_hit;
  logic attn;

  assign start_hit = bus_start & ~bus_ack & id_match;
  assign attn      = bus_start & bus_ack;

  bus_slave_hs_phase #(.HALF_CYC(HALF_CYC)) phase_i (
    .clk     (clk),
    .rst     (rst),
    .drv_stb (drv_stb),
    .smp_stb (smp_stb)
  );

  bus_slave_hs_access access_i (
    .clk       (clk),
    .rst       (rst),
    .drv_stb   (drv_stb),
    .smp_stb   (smp_stb),
    .start_hit (start_hit),
    .grant_n   (grant_n),
    .lack_n    (lack_n),
    .req_stat  (req_stat),
    .buf_en    (buf_en),
    .ack_out   (ack_out)
  );

  bus_slave_hs_lock lock_i (
    .clk      (clk),
    .rst      (rst),
    .smp_stb  (smp_stb),
    .attn     (attn),
    .lock_sel (bus_tm),
    .busy     (req_stat),
    .lock_out (lock_out)
  );
endmodule

// File: rtl/bus_slave_hs_chk.sv
module bus_slave_hs_chk (
  input logic clk,
  input logic rst,
  input logic drv_stb,
  input logic smp_stb,
  input logic bus_start,
  input logic bus_ack,
  input logic bus_tm,
  input logic id_match,
  input logic grant_n,
  input logic req_stat,
  input logic buf_en,
  input logic ack_out,
  input logic lock_out
);
  p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!drv_stb && !smp_stb) |=> $stable({req_stat, buf_en, ack_out, lock_out}));

  p_ack_on_drive_r1: assert property (@(posedge clk) disable iff (rst)
    $changed(ack_out) |-> $past(drv_stb));

  p_ack_len_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_out) |=> ack_out);

  p_req_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(req_stat) |-> $past(smp_stb && bus_start && !bus_ack && id_match));

  p_buf_in_access_r4: assert property (@(posedge clk) disable iff (rst)
    buf_en |-> req_stat);

  p_req_end_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(req_stat) |-> $past(smp_stb && grant_n));

  p_lock_set_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_out) |-> $past(smp_stb && bus_start && bus_ack && bus_tm && req_stat));

  p_lock_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_out) |-> $past(smp_stb && bus_start && bus_ack && !bus_tm));
endmodule

bind bus_slave_hs bus_slave_hs_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .drv_stb   (drv_stb),
  .smp_stb   (smp_stb),
  .bus_start (bus_start),
  .bus_ack   (bus_ack),
  .bus_tm    (bus_tm),
  .id_match  (id_match),
  .grant_n   (grant_n),
  .req_stat  (req_stat),
  .buf_en    (buf_en),
  .ack_out   (ack_out),
  .lock_out  (lock_out)
);

// File: tb/bus_slave_hs_tb_top.sv
`timescale 1ns/1ps
module bus_slave_hs_tb_top;
  localparam int HALF = 2;
  localparam int P    = 2 * HALF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_start = 1'b0, bus_ack = 1'b0, bus_tm = 1'b0, id_match = 1'b0;
  logic grant_n = 1'b1, lack_n = 1'b1;
  logic req_stat, buf_en, ack_out, lock_out;

  always #2 clk = ~clk;  // 250 MHz

  bus_slave_hs #(.HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst(rst), .bus_start(bus_start), .bus_ack(bus_ack),
    .bus_tm(bus_tm), .id_match(id_match), .grant_n(grant_n), .lack_n(lack_n),
    .req_stat(req_stat), .buf_en(buf_en), .ack_out(ack_out), .lock_out(lock_out)
  );

  // Edges since reset release; edge index e turns edges from e to e+1.
  int edges = 0;
  always @(posedge clk) if (!rst) edges <= edges + 1;

  typedef struct {
    int       at;
    logic [3:0] exp;   // {req_stat, buf_en, ack_out, lock_out}
    string    tag;
  } sb_item_t;

  sb_item_t sb[$];
  sb_item_t cur;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // Monitor: compares scoreboard items at the negedge where edges == at.
  always @(negedge clk) begin
    if (!rst) begin
      while (sb.size() > 0 && sb[0].at <= edges) begin
        cur = sb.pop_front();
        n_chk++;
        if (cur.at != edges || {req_stat, buf_en, ack_out, lock_out} !== cur.exp) begin
          n_err++;
          $display("FAIL %s at edges=%0d: actual %b expected %b (req,buf,ack,lock)",
                   cur.tag, cur.at, {req_stat, buf_en, ack_out, lock_out}, cur.exp);
        end
      end
    end
  end

  task automatic expect_at(input int at, input logic [3:0] v, input string tag);
    sb_item_t it;
    it.at = at; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic go_to(input int e);
    while (edges != e) @(negedge clk);
  endtask

  function automatic int next_smp();
    int e = edges;
    while (e % P != HALF) e++;
    return e;
  endfunction

  task automatic bus_idle();
    bus_start = 1'b0; bus_ack = 1'b0; bus_tm = 1'b0; id_match = 1'b0;
  endtask

  task automatic matched_start();
    bus_start = 1'b1; bus_ack = 1'b0; id_match = 1'b1;
  endtask

  initial begin
    int s;
    expect_at(1, 4'b0000, "R2 reset state");
    repeat (4) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);

    // Normal handshake
    s = next_smp();
    go_to(s); matched_start();
    expect_at(s + 1, 4'b1000, "R3 request on matched start");
    go_to(s + 1); bus_idle();
    go_to(s + P); grant_n = 1'b0;
    expect_at(s + P + 1, 4'b1100, "R4 buffers follow grant");
    go_to(s + 2*P); lack_n = 1'b0;
    expect_at(s + 2*P + 1, 4'b1100, "R6 no ack at sample strobe");
    expect_at(s + 2*P + HALF, 4'b1100, "R1 ack waits for drive strobe");
    expect_at(s + 2*P + HALF + 1, 4'b1110, "R6 ack at drive strobe");
    go_to(s + 2*P + HALF + 1); lack_n = 1'b1;
    go_to(s + 3*P); grant_n = 1'b1;
    expect_at(s + 3*P, 4'b1110, "R5 request held until grant release");
    expect_at(s + 3*P + 1, 4'b0010, "R5 release on grant high");
    expect_at(s + 3*P + HALF + 1, 4'b0000, "R6 ack lasts one bus period");
    go_to(s + 3*P + HALF + 2);

    // Fastest: grant and local ack low at the start sample
    s = next_smp();
    go_to(s); matched_start(); grant_n = 1'b0; lack_n = 1'b0;
    expect_at(s + 1, 4'b1100, "R7 buffers at start sample");
    expect_at(s + HALF + 1, 4'b1110, "R7 ack on next drive strobe");
    go_to(s + 1); bus_idle(); lack_n = 1'b1;
    go_to(s + P); grant_n = 1'b1;
    expect_at(s + P + 1, 4'b0010, "R5 fastest release");
    expect_at(s + P + HALF + 1, 4'b0000, "R6 fastest ack ends");
    go_to(s + P + HALF + 2);

    // Fast grant only
    s = next_smp();
    go_to(s); matched_start(); grant_n = 1'b0;
    expect_at(s + 1, 4'b1100, "R4 fast grant opens buffers");
    expect_at(s + HALF + 1, 4'b1100, "R6 no ack without local ack");
    go_to(s + 1); bus_idle();
    go_to(s + P); lack_n = 1'b0;
    expect_at(s + P + HALF + 1, 4'b1110, "R6 ack after late local ack");
    go_to(s + P + 1); lack_n = 1'b1;
    go_to(s + 2*P); grant_n = 1'b1;
    expect_at(s + 2*P + 1, 4'b0010, "R5 fast grant release");
    expect_at(s + 2*P + HALF + 1, 4'b0000, "R6 ack single pulse");
    go_to(s + 2*P + HALF + 2);

    // Non-matching start, attention with match, then held-off local ack
    s = next_smp();
    go_to(s); bus_start = 1'b1; id_match = 1'b0;
    expect_at(s + 1, 4'b0000, "R3 no access without id match");
    go_to(s + 1); bus_idle();
    go_to(s + P); bus_start = 1'b1; bus_ack = 1'b1; id_match = 1'b1; bus_tm = 1'b0;
    expect_at(s + P + 1, 4'b0000, "R3 attention cycle is not an access");
    go_to(s + P + 1); bus_idle();
    s = s + 2*P;
    go_to(s); matched_start();
    expect_at(s + 1, 4'b1000, "R3 access begins");
    go_to(s + 1); bus_idle();
    go_to(s + P); grant_n = 1'b0;
    expect_at(s + P + 1, 4'b1100, "R4 grant during access");
    go_to(s + 2*P); bus_ack = 1'b1;
    expect_at(s + 2*P + 1, 4'b1100, "R8 bus timeout ignored");
    go_to(s + 2*P + 1); bus_ack = 1'b0;
    go_to(s + 3*P); grant_n = 1'b1;
    expect_at(s + 3*P + 1, 4'b1000, "R8 request held without local ack");
    go_to(s + 4*P); matched_start();
    expect_at(s + 4*P + 1, 4'b1000, "R8 new start during access ignored");
    go_to(s + 4*P + 1); bus_idle();
    go_to(s + 5*P); lack_n = 1'b0;
    expect_at(s + 5*P + 1, 4'b1000, "R5 no release at the ack-taking sample");
    expect_at(s + 5*P + HALF + 1, 4'b1010, "R6 ack after held-off local ack");
    go_to(s + 5*P + 1); lack_n = 1'b1;
    expect_at(s + 6*P + 1, 4'b0010, "R5 release at next sample");
    expect_at(s + 6*P + HALF + 1, 4'b0000, "R6 ack ends");
    go_to(s + 6*P + HALF + 2);

    // Lock window
    s = next_smp();
    go_to(s); bus_start = 1'b1; bus_ack = 1'b1; bus_tm = 1'b1;
    expect_at(s + 1, 4'b0000, "R10 lock attention while idle ignored");
    go_to(s + 1); bus_idle();
    go_to(s + P); matched_start(); grant_n = 1'b0;
    expect_at(s + P + 1, 4'b1100, "R4 access for lock test");
    go_to(s + P + 1); bus_idle();
    go_to(s + 2*P); bus_start = 1'b1; bus_ack = 1'b1; bus_tm = 1'b1;
    expect_at(s + 2*P + 1, 4'b1101, "R9 lock set during access");
    go_to(s + 2*P + 1); bus_idle();
    go_to(s + 3*P); lack_n = 1'b0;
    expect_at(s + 3*P + HALF + 1, 4'b1111, "R6 ack with lock set");
    go_to(s + 3*P + 1); lack_n = 1'b1;
    go_to(s + 4*P); grant_n = 1'b1;
    expect_at(s + 4*P + 1, 4'b0011, "R10 lock survives access end");
    expect_at(s + 4*P + HALF + 1, 4'b0001, "R10 lock held while idle");
    go_to(s + 5*P); bus_start = 1'b1; bus_ack = 1'b1; bus_tm = 1'b0;
    expect_at(s + 5*P + 1, 4'b0000, "R10 null attention clears lock");
    go_to(s + 5*P + 1); bus_idle();
    go_to(s + 5*P + 3);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: run did not complete (actual hung, expected finished)");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule